// File: doc/BRIEF.md
# Serial Frame Transmitter with Break Control

This block turns characters into asynchronous serial frames on one output line. Characters enter through a valid/ready port into a first-in first-out queue, 64 entries deep by default. A serializer takes them from the queue one at a time and advances one bit each time the external bit-rate strobe `baud_tick` pulses. It captures the frame format from `mode_word` when each frame starts. The format sets the character length, the parity rule and the number of stop bits.

A one-cycle command strobe `ctl_wr` applies the bits of `ctl_word`. These bits enable or halt the transmitter, flush the queue, and raise or release a break. Status pins report whether a frame is on the line and whether the queue is empty or full. Back-pressure follows the usual rule: a character is taken on every rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the queue is full and in the cycle of a flush command. A sender holds `in_valid` and `in_data` steady until the character is taken.

Top module: `serial_tx_engine`

## Requirements
- R1: A character is accepted exactly on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the queue holds DEPTH (64) characters, and also in a cycle where a flush command is applied.
- R2: `q_empty` is high exactly when the queue holds no character, and `q_full` exactly when it holds DEPTH. After reset `q_empty`=1 and `q_full`=0.
- R3: A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then one or two high stop bits. Each bit lasts from one `baud_tick` to the next. The format in `mode_word` is captured when the frame starts.
- R4: Character length is set by `mode_word[1:0]`: 10 sends CHAR_W-1 bits (7), 11 sends CHAR_W-2 bits (6), and 00 or 01 sends CHAR_W bits (8).
- R5: Parity is set by `mode_word[4:2]`. Code 000 gives even parity over the sent data bits, 001 gives odd parity, 010 always sends 0, and 011 always sends 1. Any code with bit 4 set sends no parity bit.
- R6: Stop bits are set by `mode_word[6:5]`: code 10 sends two stop bits and every other code sends one.
- R7: Command bits apply when `ctl_wr`=1. `ctl_word[0]` enables the transmitter and `ctl_word[1]` disables it; if both are set, the transmitter ends up disabled. While disabled, no new frame starts and queued characters stay in the queue.
- R8: `ctl_word[2]` is a one-shot flush. It empties the queue and stops any frame on the line. From the next cycle `tx_active`=0 and the line is high, unless a break is in force.
- R9: `ctl_word[3]` requests a break and `ctl_word[4]` releases it; if both are set, the release wins. A frame already on the line completes first. After that the line stays low and no frame starts until the release, when the line goes high and queued characters are sent.
- R10: `tx_active` is high from the start of the start bit to the end of the last stop bit, and low at all other times.
- R11: With no frame on the line and no break in force, `txd` is high, including during and just after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-rate strobe; each pulse ends one bit period |
| in_valid | input | 1 | Character offered |
| in_data | input | CHAR_W | Character; the low bits are sent for short lengths |
| in_ready | output | 1 | Queue can take a character this cycle |
| ctl_wr | input | 1 | Apply `ctl_word` this cycle |
| ctl_word | input | 5 | [0] enable, [1] disable, [2] flush, [3] break on, [4] break off |
| mode_word | input | 7 | [1:0] length, [4:2] parity, [6:5] stop bits |
| txd | output | 1 | Serial line, idle high |
| tx_active | output | 1 | Frame on the line |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue full |

## Verification
The serializer registers each new bit on the clock edge that samples `baud_tick`. A bit is therefore stable from the cycle after one strobe until the edge after the next. The bench drives the strobe itself and samples the line once per bit period, three cycles after each strobe, well inside the bit. Commands and characters are driven one time unit after a rising edge and take effect on the next edge. The bench changes its own expectation of the idle level only after that edge has passed, so no sample straddles a command. Queue and status pins are registered and are read at the falling edge after the edge that updated them.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
  // Frame format word: stop code, parity code, length code.
  typedef struct packed {
    logic [1:0] stop;
    logic [2:0] par;
    logic [1:0] len;
  } fmt_t;

  // Command word, one bit per action.
  typedef struct packed {
    logic brk_off;
    logic brk_on;
    logic flush;
    logic halt;
    logic go;
  } cmd_t;
endpackage

// File: rtl/sertx_queue.sv
`timescale 1ns/1ps
module sertx_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  input  logic         clear,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clear) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // A full queue stays full until something leaves it.
  assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop && !clear |=> full);
  // An accepted character makes the queue non-empty.
  assert_push_seen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push && !full && !clear |=> !empty);
  // A clear leaves nothing behind.
  assert_clear_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);
endmodule

// File: rtl/sertx_ctrl.sv
`timescale 1ns/1ps
module sertx_ctrl (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  sertx_pkg::cmd_t  cmd,
  output logic             enabled,
  output logic             brk_req,
  output logic             flush
);
  // Flush is a pulse only; it leaves no state behind.
  assign flush = wr && cmd.flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      brk_req <= 1'b0;
    end else if (wr) begin
      if (cmd.halt)      enabled <= 1'b0;
      else if (cmd.go)   enabled <= 1'b1;
      if (cmd.brk_off)   brk_req <= 1'b0;
      else if (cmd.brk_on) brk_req <= 1'b1;
    end
  end

  assert_halt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr && cmd.halt |=> !enabled);
  assert_brk_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr && cmd.brk_off |=> !brk_req);
endmodule

// File: rtl/sertx_framer.sv
`timescale 1ns/1ps
module sertx_framer #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enabled,
  input  logic              brk_hold,
  input  logic              have_data,
  input  logic              abort,
  input  sertx_pkg::fmt_t   fmt,
  input  logic [CHAR_W-1:0] data,
  output logic              take,
  output logic              active,
  output logic              line_bit
);
  localparam int FRAME_W = 1 + CHAR_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr, frame;
  logic [CNT_W-1:0]   left, flen;
  logic [CHAR_W-1:0]  dsel;
  logic               pbit, go, at_end;
  int                 nd, np, ns;

  // Assemble the whole frame, LSB first on the wire, from the live format.
  always_comb begin
    case (fmt.len)
      2'b10:   nd = CHAR_W - 1;
      2'b11:   nd = CHAR_W - 2;
      default: nd = CHAR_W;
    endcase
    for (int i = 0; i < CHAR_W; i++) dsel[i] = (i < nd) ? data[i] : 1'b0;
    np = fmt.par[2] ? 0 : 1;
    case (fmt.par[1:0])
      2'b00:   pbit = ^dsel;
      2'b01:   pbit = ~^dsel;
      2'b10:   pbit = 1'b0;
      default: pbit = 1'b1;
    endcase
    ns = (fmt.stop == 2'b10) ? 2 : 1;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < CHAR_W; i++) if (i < nd) frame[i+1] = dsel[i];
    for (int i = 1; i < FRAME_W; i++) if (np == 1 && i == nd + 1) frame[i] = pbit;
    flen = CNT_W'(1 + nd + np + ns);
  end

  assign go       = enabled && !brk_hold && have_data;
  assign at_end   = !active || (left == CNT_W'(1));
  assign take     = tick && at_end && go && !abort;
  assign line_bit = active ? sr[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sr     <= '1;
      left   <= '0;
    end else if (abort) begin
      active <= 1'b0;
      sr     <= '1;
      left   <= '0;
    end else if (tick) begin
      if (at_end) begin
        if (go) begin
          active <= 1'b1;
          sr     <= frame;
          left   <= flen;
        end else begin
          active <= 1'b0;
          sr     <= '1;
          left   <= '0;
        end
      end else begin
        sr   <= {1'b1, sr[FRAME_W-1:1]};
        left <= left - CNT_W'(1);
      end
    end
  end

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !sr[0]);
  assert_bit_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !abort |=> $stable(sr));
  assert_ends_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) && !$past(abort) |-> $past(sr[0]));
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active);
  assert_no_start_in_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hold && !active |=> !active);
endmodule

// File: rtl/serial_tx_engine.sv
`timescale 1ns/1ps
module serial_tx_engine #(
  parameter int CHAR_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              ctl_wr,
  input  logic [4:0]        ctl_word,
  input  logic [6:0]        mode_word,
  output logic              txd,
  output logic              tx_active,
  output logic              q_empty,
  output logic              q_full
);
  import sertx_pkg::*;

  cmd_t              cmd;
  fmt_t              fmt;
  logic              enabled, brk_req, flush, take, line_bit;
  logic [CHAR_W-1:0] head;

  assign cmd      = cmd_t'(ctl_word);
  assign fmt      = fmt_t'(mode_word);
  assign in_ready = !q_full && !flush;

  sertx_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctl_wr),
    .cmd     (cmd),
    .enabled (enabled),
    .brk_req (brk_req),
    .flush   (flush)
  );

  sertx_queue #(.W(CHAR_W), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid && in_ready),
    .wdata (in_data),
    .pop   (take),
    .clear (flush),
    .rdata (head),
    .full  (q_full),
    .empty (q_empty)
  );

  sertx_framer #(.CHAR_W(CHAR_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .enabled   (enabled),
    .brk_hold  (brk_req),
    .have_data (!q_empty),
    .abort     (flush),
    .fmt       (fmt),
    .data      (head),
    .take      (take),
    .active    (tx_active),
    .line_bit  (line_bit)
  );

  // Break pulls the line low only once no frame is on it.
  assign txd = line_bit & ~(brk_req & ~tx_active);
endmodule

// File: tb/sim_serial_tx_engine.sv
`timescale 1ns/1ps
module sim_serial_tx_engine;
  localparam int CW = 8;
  localparam int DEPTH = 64;
  localparam logic [4:0] GO = 5'd1, HALT = 5'd2, FLUSH = 5'd4, BON = 5'd8, BOFF = 5'd16;

  logic clk = 0, rst_n = 0, baud_tick = 0, in_valid = 0, ctl_wr = 0;
  logic [CW-1:0] in_data = '0;
  logic [4:0] ctl_word = '0;
  logic [6:0] mode_word = '0;
  logic in_ready, txd, tx_active, q_empty, q_full;

  int n_cmp = 0, n_bad = 0;
  logic exp_brk = 0;
  logic [6:0] cur_mode = '0;
  logic exp_bits[$];
  logic [6:0] exp_mode[$];

  always #4 clk = ~clk;

  serial_tx_engine #(.CHAR_W(CW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .ctl_wr(ctl_wr), .ctl_word(ctl_word), .mode_word(mode_word),
    .txd(txd), .tx_active(tx_active), .q_empty(q_empty), .q_full(q_full));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    exp_bits.push_back(b);
    exp_mode.push_back(cur_mode);
  endtask

  // Expected frame from R3..R6.
  task automatic expect_frame(input logic [7:0] d);
    int nd;
    logic p;
    case (cur_mode[1:0])
      2'b10:   nd = 7;
      2'b11:   nd = 6;
      default: nd = 8;
    endcase
    p = 1'b0;
    put_bit(1'b0);
    for (int i = 0; i < nd; i++) begin
      put_bit(d[i]);
      p = p ^ d[i];
    end
    if (!cur_mode[4]) begin
      case (cur_mode[3:2])
        2'b00:   put_bit(p);
        2'b01:   put_bit(~p);
        2'b10:   put_bit(1'b0);
        default: put_bit(1'b1);
      endcase
    end
    put_bit(1'b1);
    if (cur_mode[6:5] == 2'b10) put_bit(1'b1);
  endtask

  // Monitor: one sample per bit period.
  task automatic sample_line();
    logic e;
    logic [6:0] m;
    if (tx_active) begin
      if (exp_bits.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R10: tx_active with no frame due, actual 1 expected 0");
      end else begin
        e = exp_bits.pop_front();
        m = exp_mode.pop_front();
        check($sformatf("R3 frame bit mode=%b", m), {31'd0, txd}, {31'd0, e});
      end
    end else begin
      check(exp_brk ? "R9 break level" : "R11 idle level", {31'd0, txd},
            exp_brk ? 32'd0 : 32'd1);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); baud_tick = 1;
      @(negedge clk); baud_tick = 0;
      @(negedge clk); @(negedge clk);
      sample_line();
      repeat (4) @(negedge clk);
    end
  end

  task automatic send(input logic [7:0] d, input bit due);
    if (due) expect_frame(d);
    @(posedge clk); #1;
    in_valid = 1; in_data = d;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic command(input logic [4:0] w);
    @(posedge clk); #1;
    ctl_wr = 1; ctl_word = w;
    @(posedge clk); #1;
    ctl_wr = 0; ctl_word = '0;
  endtask

  task automatic set_mode(input logic [6:0] m);
    @(posedge clk); #1;
    mode_word = m; cur_mode = m;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(q_empty && !tx_active && exp_bits.size() == 0));
  endtask

  task automatic wait_active();
    do @(negedge clk); while (!tx_active);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [6:0] modes [7];
    modes[0] = {2'b00, 3'b100, 2'b00};
    modes[1] = {2'b00, 3'b000, 2'b10};
    modes[2] = {2'b10, 3'b001, 2'b11};
    modes[3] = {2'b00, 3'b010, 2'b00};
    modes[4] = {2'b10, 3'b011, 2'b00};
    modes[5] = {2'b10, 3'b111, 2'b10};
    modes[6] = {2'b01, 3'b000, 2'b01};

    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check("R11 reset txd", {31'd0, txd}, 1);
    check("R10 reset tx_active", {31'd0, tx_active}, 0);
    check("R2 reset q_empty", {31'd0, q_empty}, 1);
    check("R2 reset q_full", {31'd0, q_full}, 0);
    check("R1 reset in_ready", {31'd0, in_ready}, 1);

    // R3 R4 R5 R6: back-to-back frames in every format.
    command(GO);
    for (int m = 0; m < 7; m++) begin
      set_mode(modes[m]);
      for (int k = 0; k < 3; k++) send(8'(m * 53 + k * 91 + 7), 1);
      wait_idle();
    end

    // R9: break waits for the frame on the line, holds the queue, then releases.
    set_mode(modes[0]);
    send(8'h5A, 1);
    send(8'hC3, 1);
    wait_active();
    command(BON);
    exp_brk = 1;
    do @(negedge clk); while (!(!tx_active && exp_bits.size() == 10));
    repeat (48) @(negedge clk);
    check("R9 char held during break", {31'd0, q_empty}, 0);
    check("R9 line low in break", {31'd0, txd}, 0);
    check("R10 idle during break", {31'd0, tx_active}, 0);
    command(BOFF);
    exp_brk = 0;
    wait_idle();
    command(BON | BOFF);
    repeat (24) @(negedge clk);
    check("R9 release wins", {31'd0, txd}, 1);

    // R7: disable wins when both bits are set.
    command(GO | HALT);
    send(8'h11, 0);
    repeat (48) @(negedge clk);
    check("R7 queued char not sent", {31'd0, q_empty}, 0);
    check("R7 no frame while disabled", {31'd0, tx_active}, 0);
    command(FLUSH);
    @(negedge clk);
    check("R8 flush empties queue", {31'd0, q_empty}, 1);

    // R1 R2: fill the queue while disabled.
    for (int k = 0; k < DEPTH; k++) send(8'(k), 0);
    @(negedge clk);
    check("R2 q_full at depth", {31'd0, q_full}, 1);
    check("R2 q_empty at depth", {31'd0, q_empty}, 0);
    @(posedge clk); #1;
    in_valid = 1; in_data = 8'hEE;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1 in_ready low when full", {31'd0, in_ready}, 0);
    end
    @(posedge clk); #1;
    in_valid = 0;
    command(FLUSH);
    @(negedge clk);
    check("R8 flush clears full", {31'd0, q_full}, 0);
    check("R8 flush empties queue", {31'd0, q_empty}, 1);
    check("R1 ready after flush", {31'd0, in_ready}, 1);

    // R8: flush in mid-frame stops it; R7: re-enable works.
    command(GO);
    send(8'h96, 1);
    send(8'h69, 0);
    wait_active();
    repeat (24) @(negedge clk);
    command(FLUSH);
    exp_bits.delete();
    exp_mode.delete();
    @(negedge clk);
    check("R8 abort drops tx_active", {31'd0, tx_active}, 0);
    check("R8 abort line high", {31'd0, txd}, 1);
    check("R8 abort empties queue", {31'd0, q_empty}, 1);
    repeat (40) @(negedge clk);
    check("R8 nothing sent after abort", {31'd0, tx_active}, 0);
    send(8'h42, 1);
    wait_idle();

    check("R3 all expected bits seen", exp_bits.size(), 0);
    finish_run();
  end
endmodule